// File: doc/BRIEF.md
# Eight-bit ALU with flags

A purely combinational arithmetic and logic unit for the execute stage of a small pipelined processor. It takes two 8-bit operands and the processor's opcode byte as its control code. It returns an 8-bit result and four status flags: negative, overflow, zero and carry. The unit has no clock and no state. A new operand or code pair gives its result in the same cycle, so the surrounding pipeline register can capture it at the next edge.

The arithmetic group covers add, subtract, multiply and divide. The comparison group covers less-than, greater-than and equal, each returning a boolean byte. The logic group covers NOT, AND and OR. Instructions that do not need the unit, such as moves, immediate loads, loads and stores, present code 0x00. For that code, and for any code outside the defined set, the unit gives an all-zero result with every flag clear. The datapath can therefore route around the unit without special handling.

Top module: `alu8_flags`

## Requirements
- R1: Code 0x01 (add) gives result = (A + B) mod 256. C is set on a carry out of bit 7. O is set when A and B have the same bit 7 and the result's bit 7 differs from it.
- R2: Code 0x03 (subtract) gives result = (A − B) mod 256. C is set when A < B as unsigned values (a borrow). O is set when A and B differ in bit 7 and the result's bit 7 differs from A's.
- R3: Code 0x02 (multiply) gives the low 8 bits of the unsigned product A·B. C is set when the upper 8 bits of the product are nonzero. O is 0.
- R4: Code 0x04 (divide) gives the unsigned quotient A / B with O = 0 when B ≠ 0. When B = 0 it gives 0xFF with O = 1. C is 0 in both cases.
- R5: Codes 0x09 (A < B), 0x0A (A > B) and 0x0B (A == B) compare the operands as unsigned values. The result is 0x01 when the relation holds and 0x00 when it does not.
- R6: Code 0x0C gives the bitwise inverse of A with B ignored. Code 0x0D gives A AND B. Code 0x0E gives A OR B.
- R7: For every defined code, N equals bit 7 of the result and Z is set exactly when the result is 0x00. C and O are 0 except where R1–R4 set them.
- R8: Code 0x00, and every code other than 0x01–0x04 and 0x09–0x0E, gives result 0x00 with N, O, Z and C all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| ctrlCode | input | 8 | Opcode byte selecting the operation |
| result | output | 8 | Operation result |
| flagN | output | 1 | Negative flag (result bit 7) |
| flagO | output | 1 | Overflow flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry / borrow / high-product flag |

## Verification
Assertions check some properties for every input. The decoded operation is at most one-hot. N and Z agree with the result whenever an operation is selected. A comparison never returns anything but 0x00 or 0x01. Division by zero always yields 0xFF with O set. An unselected unit drives all zeros. Only the bench's scenarios can show that each arithmetic value and each carry and overflow flag is numerically right: sign-boundary operands for overflow, products that spill past eight bits, and undefined codes scattered across the code space.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] CODE_ADD = 8'h01;
  localparam logic [CODE_W-1:0] CODE_MUL = 8'h02;
  localparam logic [CODE_W-1:0] CODE_SUB = 8'h03;
  localparam logic [CODE_W-1:0] CODE_DIV = 8'h04;
  localparam logic [CODE_W-1:0] CODE_LT  = 8'h09;
  localparam logic [CODE_W-1:0] CODE_GT  = 8'h0A;
  localparam logic [CODE_W-1:0] CODE_EQ  = 8'h0B;
  localparam logic [CODE_W-1:0] CODE_NOT = 8'h0C;
  localparam logic [CODE_W-1:0] CODE_AND = 8'h0D;
  localparam logic [CODE_W-1:0] CODE_OR  = 8'h0E;

  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doMul;
    logic doDiv;
    logic doLt;
    logic doGt;
    logic doEq;
    logic doNot;
    logic doAnd;
    logic doOr;
  } aluStrobes_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [CODE_W-1:0] ctrlCode,
  output aluStrobes_t       strobes
);
  always_comb begin
    strobes = '0;
    unique case (ctrlCode)
      CODE_ADD: strobes.doAdd = 1'b1;
      CODE_SUB: strobes.doSub = 1'b1;
      CODE_MUL: strobes.doMul = 1'b1;
      CODE_DIV: strobes.doDiv = 1'b1;
      CODE_LT:  strobes.doLt  = 1'b1;
      CODE_GT:  strobes.doGt  = 1'b1;
      CODE_EQ:  strobes.doEq  = 1'b1;
      CODE_NOT: strobes.doNot = 1'b1;
      CODE_AND: strobes.doAnd = 1'b1;
      CODE_OR:  strobes.doOr  = 1'b1;
      default:  strobes = '0;
    endcase
    // R8: at most one operation may be selected for any code
    p_single_op_r8: assert ($onehot0(strobes))
      else $error("decoder selected more than one operation");
  end
endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagO,
  output logic             flagZ,
  output logic             flagC
);
  localparam int MSB = WIDTH - 1;
  localparam int PW  = 2 * WIDTH;

  logic [WIDTH:0]   sumExt;
  logic [WIDTH:0]   difExt;
  logic [PW-1:0]    prodFull;
  logic [WIDTH-1:0] quot;
  logic             divZero;
  logic             anyOp;
  logic [WIDTH-1:0] res;
  logic             cOut;
  logic             oOut;

  always_comb begin
    sumExt   = {1'b0, opA} + {1'b0, opB};
    difExt   = {1'b0, opA} - {1'b0, opB};
    prodFull = {{WIDTH{1'b0}}, opA} * {{WIDTH{1'b0}}, opB};
    divZero  = (opB == '0);
    quot     = divZero ? '1 : (opA / opB);
    anyOp    = |strobes;
    res      = '0;
    cOut     = 1'b0;
    oOut     = 1'b0;

    if (strobes.doAdd) begin
      res  = sumExt[MSB:0];
      cOut = sumExt[WIDTH];
      oOut = (opA[MSB] == opB[MSB]) && (sumExt[MSB] != opA[MSB]);
    end
    if (strobes.doSub) begin
      res  = difExt[MSB:0];
      cOut = difExt[WIDTH];
      oOut = (opA[MSB] != opB[MSB]) && (difExt[MSB] != opA[MSB]);
    end
    if (strobes.doMul) begin
      res  = prodFull[MSB:0];
      cOut = |prodFull[PW-1:WIDTH];
    end
    if (strobes.doDiv) begin
      res  = quot;
      oOut = divZero;
    end
    if (strobes.doLt)  res = {{(WIDTH-1){1'b0}}, opA < opB};
    if (strobes.doGt)  res = {{(WIDTH-1){1'b0}}, opA > opB};
    if (strobes.doEq)  res = {{(WIDTH-1){1'b0}}, opA == opB};
    if (strobes.doNot) res = ~opA;
    if (strobes.doAnd) res = opA & opB;
    if (strobes.doOr)  res = opA | opB;

    result = res;
    flagC  = cOut;
    flagO  = oOut;
    flagN  = anyOp & res[MSB];
    flagZ  = anyOp & (res == '0);

    if (anyOp) begin
      p_sign_zero_r7: assert ((flagN == result[MSB]) && (flagZ == (result == '0)))
        else $error("N/Z disagree with result");
    end else begin
      p_idle_zero_r8: assert ((result == '0) && !flagN && !flagO && !flagZ && !flagC)
        else $error("unselected unit drives nonzero outputs");
    end
    if (strobes.doLt || strobes.doGt || strobes.doEq) begin
      p_bool_byte_r5: assert (result[MSB:1] == '0 && !flagC && !flagO)
        else $error("comparison not boolean");
    end
    if (strobes.doDiv && divZero) begin
      p_div_zero_r4: assert ((result == '1) && flagO && !flagC)
        else $error("divide by zero mishandled");
    end
    if (strobes.doMul) begin
      p_no_overflow_r3: assert (!flagO)
        else $error("multiply raised overflow");
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [CODE_W-1:0] ctrlCode,
  output logic [WIDTH-1:0]  result,
  output logic              flagN,
  output logic              flagO,
  output logic              flagZ,
  output logic              flagC
);
  aluStrobes_t strobes;

  alu8_ctrl u_ctrl (
    .ctrlCode (ctrlCode),
    .strobes  (strobes)
  );

  alu8_dp #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .flagN   (flagN),
    .flagO   (flagO),
    .flagZ   (flagZ),
    .flagC   (flagC)
  );
endmodule

// File: tb/alu8_flags_test.sv
`timescale 1ns/1ps
module alu8_flags_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] opA = '0, opB = '0, ctrlCode = '0;
  logic [7:0] result;
  logic flagN, flagO, flagZ, flagC;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  bit done = 0;

  alu8_flags uut (
    .opA(opA), .opB(opB), .ctrlCode(ctrlCode),
    .result(result), .flagN(flagN), .flagO(flagO), .flagZ(flagZ), .flagC(flagC)
  );

  // Behavioural reference: returns {N,O,Z,C,result}
  function automatic logic [11:0] model(input int a, input int b, input int code);
    int r = 0;
    bit c = 0, o = 0, known = 1;
    bit sa = a >= 128, sb = b >= 128;
    case (code)
      1:  begin r = (a + b) % 256; c = (a + b) > 255;
                o = (sa == sb) && ((r >= 128) != sa); end
      3:  begin r = (a - b + 256) % 256; c = a < b;
                o = (sa != sb) && ((r >= 128) != sa); end
      2:  begin r = (a * b) % 256; c = (a * b) > 255; end
      4:  begin if (b == 0) begin r = 255; o = 1; end else r = a / b; end
      9:  r = (a < b) ? 1 : 0;
      10: r = (a > b) ? 1 : 0;
      11: r = (a == b) ? 1 : 0;
      12: r = 255 - a;
      13: r = a & b;
      14: r = a | b;
      default: known = 0;
    endcase
    if (!known) return 12'h000;
    return {r >= 128, o, r == 0, c, 8'(r)};
  endfunction

  function automatic string tagOf(input int code, input int b);
    case (code)
      1: return "R1";
      3: return "R2";
      2: return "R3";
      4: return (b == 0) ? "R4 (div by zero)" : "R4";
      9, 10, 11: return "R5";
      12, 13, 14: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input int a, input int b, input int code);
    logic [11:0] exp, got;
    @(negedge clk);
    opA = 8'(a); opB = 8'(b); ctrlCode = 8'(code);
    @(posedge clk);
    #1;
    exp = model(a, b, code);
    got = {flagN, flagO, flagZ, flagC, result};
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s/R7 A=%02h B=%02h code=%02h: got NOZC=%04b res=%02h, expected NOZC=%04b res=%02h",
               tagOf(code, b), a, b, code, got[11:8], got[7:0], exp[11:8], exp[7:0]);
    end
  endtask

  initial begin
    int codes[19] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, 16, 128, 255};
    int corner[8] = '{0, 1, 127, 128, 129, 254, 255, 16};
    repeat (3) @(posedge clk);
    #1;
    // reset-state check: code 0 with zero operands -> all outputs zero (R8)
    vectors++;
    if ({flagN, flagO, flagZ, flagC, result} !== 12'h000) begin
      misses++;
      $display("FAIL R8 idle: got %03h expected 000", {flagN, flagO, flagZ, flagC, result});
    end
    rstN = 1'b1;
    // directed boundary cases
    apply(8'h7F, 8'h01, 1);   // R1 signed overflow, no carry
    apply(8'hFF, 8'h01, 1);   // R1 carry, zero result
    apply(8'h80, 8'h80, 1);   // R1 carry and overflow
    apply(8'h00, 8'h01, 3);   // R2 borrow
    apply(8'h80, 8'h01, 3);   // R2 overflow
    apply(8'h10, 8'h10, 3);   // R2 zero
    apply(8'h10, 8'h10, 2);   // R3 high byte nonzero
    apply(8'h0F, 8'h11, 2);   // R3 no spill, 0xFF
    apply(8'h37, 8'h00, 4);   // R4 divide by zero
    apply(8'hC8, 8'h07, 4);   // R4 quotient
    apply(8'h05, 8'h05, 9);   // R5 equal operands
    apply(8'h05, 8'h05, 11);  // R5
    apply(8'h05, 8'h06, 10);  // R5
    apply(8'hA5, 8'h3C, 12);  // R6 NOT ignores B
    apply(8'hA5, 8'h00, 12);  // R6 same A, other B
    apply(8'h00, 8'h00, 13);  // R7 Z on logic zero
    apply(8'hA5, 8'h3C, 0);   // R8 bypass code
    apply(8'hFF, 8'hFF, 8'h0F); // R8 undefined
    // corner grid over every code
    foreach (codes[k])
      foreach (corner[i])
        foreach (corner[j])
          apply(corner[i], corner[j], codes[k]);
    // pseudo-random sweep
    foreach (codes[k])
      for (int n = 0; n < 300; n++)
        apply($urandom_range(255), $urandom_range(255), codes[k]);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        misses++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
      end
    end
  end
endmodule